// File: doc/BRIEF.md
# Tapped Ripple Divider with Gated Oscillator Outputs

This block is a fourteen-stage binary divider. The incoming clock advances it on each falling edge, and an active-high clear resets it asynchronously. Stage 1 toggles on the falling edge of the input clock. Each later stage toggles on the falling edge of the stage below it. Stage n therefore divides the input frequency by 2^n and changes once every 2^(n-1) falling edges. The ports carry ten of the fourteen stages: stages 4 to 10 and stages 12 to 14. Stages 1 to 3 and stage 11 stay inside the block.

The block also models the digital part of an oscillator stage. It buffers the input clock onto two outputs, one in phase and one inverted. While clear is high, the oscillator is treated as stopped. The in-phase output is then parked high and the inverted output is parked low, whatever the input clock does. A parameter selects how the count chain is built: a cascade of toggle stages, each clocked by its neighbour (the default), or one equivalent falling-edge counter.

Top module: `ripple_tap_divider`

## Requirements
- R1: The chain has 14 stages. Stage 1 toggles on each falling edge of `clk_in`, and stage n (n > 1) toggles on each falling edge of stage n-1.
- R2: While `clr` is low, each falling edge of `clk_in` raises the count by one. Rising edges leave the count unchanged.
- R3: While `clr` is high, every bit of `tap` is 0, even while `clk_in` keeps toggling.
- R4: While `clr` is high, `osc_p` is 1 and `osc_n` is 0.
- R5: Stage n carries weight 2^(n-1) in the count. `tap[6:0]` holds stages 4 through 10, with bit 0 = stage 4. `tap[9:7]` holds stages 12 through 14, with bit 7 = stage 12. Stages 1 to 3 and stage 11 are not brought out.
- R6: The count wraps from all ones to zero on the 16384th falling edge, and no flag or other output marks the wrap.
- R7: While `clr` is low, `osc_p` equals `clk_in` and `osc_n` equals its inverse.
- R8: Clear takes effect on assertion without any clock edge: `tap` reads 0 once `clr` has risen, within the same clock phase.
- R9: After `clr` is released at least a setup interval before a falling edge of `clk_in`, that falling edge is counted, so the count reads 1 after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Count clock; falling edges advance the divider |
| clr | input | 1 | Asynchronous active-high clear; also stops the oscillator outputs |
| tap | output | 10 | Stage outputs 4–10 (bits 6:0) and 12–14 (bits 9:7) |
| osc_p | output | 1 | Buffered clock, in phase; held high during clear |
| osc_n | output | 1 | Buffered clock, inverted; held low during clear |

## Verification
The assertions assume that `clr` never changes in the same instant as a falling edge of `clk_in`. This rules out the race between a clear release and a counting edge. They also assume that `clk_in` keeps running, so that the clear check is sampled. The stimulus moves `clr` only one nanosecond after a rising edge, which leaves three nanoseconds of setup before the next falling edge. The clock runs through every clear pulse. The sweep covers all 16384 count values and continues past the wrap. One clear pulse lands in the middle of the count, and the bench checks the release edge after it.

// File: rtl/rtd_pkg.sv
package rtd_pkg;
    localparam int STAGES     = 14;
    localparam int FIRST_TAP  = 4;
    localparam int SKIP_STAGE = 11;
    localparam int NUM_TAPS   = STAGES - FIRST_TAP;

    // stage number (1-based) that drives tap bit k
    function automatic int stage_of_tap(input int k);
        int s;
        s = FIRST_TAP + k;
        if (s >= SKIP_STAGE) s = s + 1;
        return s;
    endfunction
endpackage

// File: rtl/rtd_stage.sv
module rtd_stage (
    input  logic t_in,
    input  logic clr,
    output logic q
);
    always_ff @(negedge t_in or posedge clr) begin
        if (clr) q <= 1'b0;
        else     q <= ~q;
    end

    // one edge of history since the last clear, used only by the check
    logic settled;
    always_ff @(negedge t_in or posedge clr) begin
        if (clr) settled <= 1'b0;
        else     settled <= 1'b1;
    end

    // R1
    stage_toggle_chk: assert property (@(negedge t_in) disable iff (clr)
        settled |-> (q != $past(q)));
endmodule

// File: rtl/rtd_chain.sv
module rtd_chain #(
    parameter int N      = rtd_pkg::STAGES,
    parameter bit RIPPLE = 1'b1
) (
    input  logic         clk_in,
    input  logic         clr,
    output logic [N-1:0] count
);
    generate
        if (RIPPLE) begin : g_ripple
            logic [N:0] edge_src;
            assign edge_src[0] = clk_in;
            for (genvar i = 0; i < N; i++) begin : g_stage
                rtd_stage u_stage (
                    .t_in (edge_src[i]),
                    .clr  (clr),
                    .q    (edge_src[i+1])
                );
            end
            assign count = edge_src[N:1];
        end else begin : g_flat
            logic [N-1:0] cnt_q;
            always_ff @(negedge clk_in or posedge clr) begin
                if (clr) cnt_q <= '0;
                else     cnt_q <= cnt_q + 1'b1;
            end
            assign count = cnt_q;
        end
    endgenerate
endmodule

// File: rtl/rtd_osc.sv
module rtd_osc (
    input  logic clk_in,
    input  logic clr,
    output logic osc_p,
    output logic osc_n
);
    always_comb begin
        osc_n = clr ? 1'b0 : ~clk_in;
        osc_p = clr ? 1'b1 : clk_in;
    end
endmodule

// File: rtl/ripple_tap_divider.sv
module ripple_tap_divider #(
    parameter bit RIPPLE = 1'b1
) (
    input  logic                          clk_in,
    input  logic                          clr,
    output logic [rtd_pkg::NUM_TAPS-1:0]  tap,
    output logic                          osc_p,
    output logic                          osc_n
);
    import rtd_pkg::*;

    logic [STAGES-1:0] count;

    rtd_chain #(.N(STAGES), .RIPPLE(RIPPLE)) u_chain (
        .clk_in (clk_in),
        .clr    (clr),
        .count  (count)
    );

    generate
        for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
            assign tap[k] = count[stage_of_tap(k) - 1];
        end
    endgenerate

    rtd_osc u_osc (
        .clk_in (clk_in),
        .clr    (clr),
        .osc_p  (osc_p),
        .osc_n  (osc_n)
    );

    // R4
    always_comb begin
        if (clr) osc_park_chk: assert (osc_p && !osc_n);
    end

    // R7
    always_comb begin
        osc_pair_chk: assert (osc_p != osc_n);
    end

    // R3
    clear_zero_chk: assert property (@(posedge clk_in)
        clr |-> (tap == '0));
endmodule

// File: tb/ripple_tap_divider_tb.sv
module ripple_tap_divider_tb;
    logic       clk_in = 1'b1;
    logic       clr    = 1'b1;
    logic [9:0] tap;
    logic       osc_p, osc_n;

    int tests = 0;
    int fails = 0;
    int ref_cnt = 0;   // total counted falling edges since last clear
    bit done = 0;

    ripple_tap_divider u_dut (
        .clk_in (clk_in), .clr (clr), .tap (tap),
        .osc_p (osc_p), .osc_n (osc_n)
    );

    always #4 clk_in = ~clk_in;   // 125 MHz

    function automatic logic [9:0] expect_tap(input int c);
        logic [13:0] v;
        v = 14'(c % 16384);
        return {v[13:11], v[9:3]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        fork
            begin
                // clear held from time zero, clock running
                #1;
                chk("R8", {22'd0, tap}, 0);
                for (int i = 0; i < 3; i++) begin
                    @(negedge clk_in); #2;
                    chk("R3", {22'd0, tap}, 0);
                    chk("R4", {30'd0, osc_p, osc_n}, 32'b10);
                    @(posedge clk_in); #2;
                    chk("R3", {22'd0, tap}, 0);
                    chk("R4", {30'd0, osc_p, osc_n}, 32'b10);
                end
                // release 1 ns after a rising edge
                @(posedge clk_in); #1; clr = 1'b0; ref_cnt = 0;
                @(negedge clk_in); ref_cnt++; #2;
                chk("R9", {22'd0, tap}, {22'd0, expect_tap(ref_cnt)});
                // full sweep past the wrap
                for (int i = 0; i < 16384 + 40; i++) begin
                    @(posedge clk_in); #2;
                    chk("R2 rising", {22'd0, tap}, {22'd0, expect_tap(ref_cnt)});
                    chk("R7 high", {30'd0, osc_p, osc_n}, 32'b10);
                    @(negedge clk_in); ref_cnt++; #2;
                    chk("R2/R5", {22'd0, tap}, {22'd0, expect_tap(ref_cnt)});
                    chk("R7 low", {30'd0, osc_p, osc_n}, 32'b01);
                    if (ref_cnt == 16384) chk("R6", {22'd0, tap}, 0);
                    if (ref_cnt == 16384 + 8) chk("R1 stage4", {31'd0, tap[0]}, 1);
                end
                // mid-count clear pulse
                @(posedge clk_in); #1; clr = 1'b1; ref_cnt = 0;
                #1;
                chk("R8", {22'd0, tap}, 0);
                chk("R4", {30'd0, osc_p, osc_n}, 32'b10);
                for (int i = 0; i < 3; i++) begin
                    @(negedge clk_in); #2;
                    chk("R3", {22'd0, tap}, 0);
                end
                @(posedge clk_in); #1; clr = 1'b0;
                @(negedge clk_in); ref_cnt++; #2;
                chk("R9", {22'd0, tap}, {22'd0, expect_tap(ref_cnt)});
                for (int i = 0; i < 2100; i++) begin
                    @(negedge clk_in); ref_cnt++; #2;
                end
                chk("R5 stage12", {31'd0, tap[7]}, ((ref_cnt >> 11) & 1));
                chk("R5 full", {22'd0, tap}, {22'd0, expect_tap(ref_cnt)});
                done = 1;
            end
            begin
                #(200000 * 8);
                if (!done) begin
                    tests++; fails++;
                    $display("FAIL watchdog actual=hung expected=done");
                end
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule